// File: doc/BRIEF.md
# Timed Test Coprocessor

This block sits beside a processor core and answers its coprocessor requests. It holds sixteen 32-bit general registers. The core reaches them through single register moves and through load/store transfers that can span several beats. It also serves a short set of commands. These commands stall the core for a programmed number of cycles, arm delayed active-low fast and normal interrupt lines, release those lines, and capture a free-running cycle counter into a register.

Each request carries a kind (register read, register write, load, store, command) and a phase (first, busy or data). It also carries a unit select. Unit 0 is the wait-only unit: it serves loads, stores, register moves and the stall command. Unit 1 is the interrupt unit: it serves register moves and all six commands, and it refuses loads and stores. The response is computed in the same cycle as the request. Register and line updates take effect at the next rising edge.

Top module: `tcop_top`

## Requirements
- R1: After synchronous reset both `nfiq_o` and `nirq_o` are high and every register reads 0.
- R2: A register write (`op_i`=1) stores `wdata_i` in the register picked by `instr_i[19:16]`. A register read (`op_i`=0) returns that register on `rdata_o` in the same cycle. Both answer done (`resp_o`=0).
- R3: Loads (`op_i`=2) and stores (`op_i`=3) on unit 0 pick the register with `instr_i[15:12]`. The first phase (`phase_i`=0) answers done and restarts the beat count. Each data phase (`phase_i`=2) moves one word. When `instr_i[22]` is set, the first LONG_BEATS-1 data beats answer increment (`resp_o`=3) and the last answers done. Increment is never given otherwise.
- R4: Command 0 (`instr_i[23:20]`) in the first phase reads a count from the register picked by `instr_i[3:0]`. A zero count answers done at once. A count N answers busy (`resp_o`=1), and later busy-phase (`phase_i`=1) requests answer busy until N cycles have elapsed since the first phase, then done.
- R5: Command 1 drives `nfiq_o` low N rising edges after the command's edge, where N is the register picked by `instr_i[3:0]`. N=0 drives it low at the command's own edge.
- R6: Command 2 does the same as command 1 for `nirq_o`.
- R7: Command 3 sets `nfiq_o` high and command 4 sets `nirq_o` high at the next edge. Each also cancels a pending delay on its line.
- R8: Command 5 writes the current cycle counter into the register picked by `instr_i[3:0]`. The counter rises by one every cycle and wraps, so two captures K cycles apart differ by K.
- R9: These requests answer cannot-handle (`resp_o`=2) and change neither registers nor lines: command values above 5, any nonzero command on unit 0, and loads or stores on unit 1.
- R10: A new delay command on a line whose delay is still pending replaces the old delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request present this cycle |
| op_i | input | 3 | Kind: 0 read, 1 write, 2 load, 3 store, 4 command |
| phase_i | input | 2 | 0 first, 1 busy, 2 data |
| unit_i | input | 1 | 0 wait-only unit, 1 interrupt unit |
| instr_i | input | 32 | Instruction word carrying the index and command fields |
| wdata_i | input | 32 | Data for writes and load beats |
| resp_o | output | 2 | 0 done, 1 busy, 2 cannot-handle, 3 increment |
| rdata_o | output | 32 | Data for reads and store beats |
| nfiq_o | output | 1 | Active-low fast interrupt line |
| nirq_o | output | 1 | Active-low normal interrupt line |

## Verification
The properties assume the core follows the handshake. A request holds its kind, phase and instruction for one cycle. Busy-phase command requests come only after a first phase of the same stall. Data-phase beats come only after a first phase of the same transfer. The stimulus is built from tasks that issue exactly these sequences, one request per cycle. The delays it programs are small, so every timed event falls inside the observed window. The bench samples line state on idle cycles only, so no request overlaps a timed edge.

// File: rtl/tcop_pkg.sv
// Package: shared encodings for the timed test coprocessor.
// Assumes: the core drives op/phase with these codes.
package tcop_pkg;
    typedef enum logic [2:0] {
        OP_RD    = 3'd0,
        OP_WR    = 3'd1,
        OP_LOAD  = 3'd2,
        OP_STORE = 3'd3,
        OP_CMD   = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        PH_FIRST = 2'd0,
        PH_BUSY  = 2'd1,
        PH_DATA  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        RS_DONE = 2'd0,
        RS_BUSY = 2'd1,
        RS_CANT = 2'd2,
        RS_INC  = 2'd3
    } resp_e;

    localparam int CMD_WAIT    = 0;
    localparam int CMD_FIQ     = 1;
    localparam int CMD_IRQ     = 2;
    localparam int CMD_FIQ_REL = 3;
    localparam int CMD_IRQ_REL = 4;
    localparam int CMD_STAMP   = 5;
endpackage

// File: rtl/tcop_regbank.sv
// Register bank: NREGS words, two combinational read ports, one write port.
// Assumes: at most one write per cycle; contents clear on reset.
module tcop_regbank #(
    parameter int DW    = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] raddr_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [DW-1:0]    rd_a,
    output logic [DW-1:0]    rd_b,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [DW-1:0]    wval
);
    localparam int NREGS = 2 ** IDX_W;

    logic [DW-1:0] mem [NREGS];

    // Storage update: clear on reset, else single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wval;
        end
    end

    // Read ports.
    assign rd_a = mem[raddr_a];
    assign rd_b = mem[raddr_b];
endmodule

// File: rtl/tcop_irq_line.sv
// One delayed active-low interrupt line with its own down-counter.
// Assumes: release wins over schedule in the same cycle; a schedule
// replaces any pending delay; value 0 asserts at the command's edge.
module tcop_irq_line #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sched,
    input  logic [DW-1:0] sched_val,
    input  logic          release_i,
    output logic          line_n
);
    logic [DW-1:0] cnt;

    // Line and delay counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_n <= 1'b1;
            cnt    <= '0;
        end else if (release_i) begin
            line_n <= 1'b1;
            cnt    <= '0;
        end else if (sched) begin
            if (sched_val == '0) line_n <= 1'b0;
            cnt <= sched_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == DW'(1)) line_n <= 1'b0;
        end
    end
endmodule

// File: rtl/tcop_ctrl.sv
// Request decoder: computes the response and read data in the same cycle,
// issues register writes and line controls, and tracks the stall window
// and the load/store beat count.
// Assumes: one request per cycle; busy/data phases follow their first phase.
module tcop_ctrl
    import tcop_pkg::*;
#(
    parameter int DW         = 32,
    parameter int IDX_W      = 4,
    parameter int LONG_BEATS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [2:0]       op_i,
    input  logic [1:0]       phase_i,
    input  logic             unit_i,
    input  logic [31:0]      instr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [DW-1:0]    rd_a,
    input  logic [DW-1:0]    rd_b,
    input  logic [DW-1:0]    tnow,
    output logic [IDX_W-1:0] raddr_a,
    output logic [IDX_W-1:0] raddr_b,
    output logic             we,
    output logic [IDX_W-1:0] waddr,
    output logic [DW-1:0]    wval,
    output logic [1:0]       resp_o,
    output logic [DW-1:0]    rdata_o,
    output logic [1:0]       sched,
    output logic [DW-1:0]    sched_val,
    output logic [1:0]       rel
);
    localparam int BW = $clog2(LONG_BEATS + 1);

    op_e           opc;
    phase_e        ph;
    resp_e         rs;
    logic [3:0]    cmd;
    logic          is_xfer;
    logic [BW-1:0] beat;
    logic          beat_inc, beat_clr, wait_arm;
    logic [DW-1:0] wait_start, wait_len;

    assign opc       = op_e'(op_i);
    assign ph        = phase_e'(phase_i);
    assign cmd       = instr_i[23:20];
    assign is_xfer   = (opc == OP_LOAD) || (opc == OP_STORE);
    assign raddr_a   = is_xfer ? instr_i[12 +: IDX_W] : instr_i[16 +: IDX_W];
    assign raddr_b   = instr_i[0 +: IDX_W];
    assign sched_val = rd_b;
    assign resp_o    = rs;

    // Request decode and response selection.
    always_comb begin
        rs       = RS_DONE;
        rdata_o  = '0;
        we       = 1'b0;
        waddr    = raddr_a;
        wval     = wdata_i;
        sched    = 2'b00;
        rel      = 2'b00;
        beat_inc = 1'b0;
        beat_clr = 1'b0;
        wait_arm = 1'b0;
        if (req_i) begin
            case (opc)
                OP_RD: rdata_o = rd_a;
                OP_WR: we = 1'b1;
                OP_LOAD, OP_STORE: begin
                    if (unit_i) begin
                        rs = RS_CANT;
                    end else if (ph == PH_DATA) begin
                        if (opc == OP_STORE) rdata_o = rd_a;
                        else                 we = 1'b1;
                        if (instr_i[22] && beat != BW'(LONG_BEATS - 1)) begin
                            rs       = RS_INC;
                            beat_inc = 1'b1;
                        end else begin
                            beat_clr = 1'b1;
                        end
                    end else begin
                        beat_clr = 1'b1;
                    end
                end
                OP_CMD: begin
                    if (!unit_i && cmd != 4'd0) begin
                        rs = RS_CANT;
                    end else begin
                        case (cmd)
                            4'(CMD_WAIT): begin
                                if (ph == PH_FIRST) begin
                                    wait_arm = 1'b1;
                                    rs = (rd_b == '0) ? RS_DONE : RS_BUSY;
                                end else if (ph == PH_BUSY) begin
                                    rs = ((tnow - wait_start) >= wait_len) ? RS_DONE : RS_BUSY;
                                end else begin
                                    rs = RS_CANT;
                                end
                            end
                            4'(CMD_FIQ):     sched[0] = (ph == PH_FIRST);
                            4'(CMD_IRQ):     sched[1] = (ph == PH_FIRST);
                            4'(CMD_FIQ_REL): rel[0]   = (ph == PH_FIRST);
                            4'(CMD_IRQ_REL): rel[1]   = (ph == PH_FIRST);
                            4'(CMD_STAMP): begin
                                we    = (ph == PH_FIRST);
                                waddr = raddr_b;
                                wval  = tnow;
                            end
                            default: rs = RS_CANT;
                        endcase
                    end
                end
                default: rs = RS_CANT;
            endcase
        end
    end

    // Beat counter for long transfers.
    always_ff @(posedge clk) begin
        if (!rst_n || beat_clr) beat <= '0;
        else if (beat_inc)      beat <= beat + 1'b1;
    end

    // Stall window capture on the first phase of a wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_start <= '0;
            wait_len   <= '0;
        end else if (wait_arm) begin
            wait_start <= tnow;
            wait_len   <= rd_b;
        end
    end
endmodule

// File: rtl/tcop_top.sv
// Timed test coprocessor top: register bank, decoder, free-running cycle
// counter and two delayed interrupt lines (index 0 fast, 1 normal).
// Assumes: synchronous active-low reset; counter wraps modulo 2**DW.
module tcop_top #(
    parameter int DW         = 32,
    parameter int IDX_W      = 4,
    parameter int LONG_BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [2:0]    op_i,
    input  logic [1:0]    phase_i,
    input  logic          unit_i,
    input  logic [31:0]   instr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [1:0]    resp_o,
    output logic [DW-1:0] rdata_o,
    output logic          nfiq_o,
    output logic          nirq_o
);
    localparam int NLINES = 2;

    logic [DW-1:0]    tnow;
    logic [IDX_W-1:0] raddr_a, raddr_b, waddr;
    logic [DW-1:0]    rd_a, rd_b, wval, sched_val;
    logic             we;
    logic [1:0]       sched, rel;
    logic [NLINES-1:0] line_n;

    // Free-running cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) tnow <= '0;
        else        tnow <= tnow + 1'b1;
    end

    tcop_regbank #(.DW(DW), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .raddr_a(raddr_a), .raddr_b(raddr_b),
        .rd_a(rd_a), .rd_b(rd_b), .we(we), .waddr(waddr), .wval(wval)
    );

    tcop_ctrl #(.DW(DW), .IDX_W(IDX_W), .LONG_BEATS(LONG_BEATS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i),
        .phase_i(phase_i), .unit_i(unit_i), .instr_i(instr_i),
        .wdata_i(wdata_i), .rd_a(rd_a), .rd_b(rd_b), .tnow(tnow),
        .raddr_a(raddr_a), .raddr_b(raddr_b), .we(we), .waddr(waddr),
        .wval(wval), .resp_o(resp_o), .rdata_o(rdata_o), .sched(sched),
        .sched_val(sched_val), .rel(rel)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        tcop_irq_line #(.DW(DW)) u_line (
            .clk(clk), .rst_n(rst_n), .sched(sched[g]),
            .sched_val(sched_val), .release_i(rel[g]), .line_n(line_n[g])
        );
    end

    assign nfiq_o = line_n[0];
    assign nirq_o = line_n[1];
endmodule

// File: rtl/tcop_checks.sv
// Checker: temporal properties on the coprocessor's ports and its counter.
// Assumes: the core follows the request handshake described in the brief.
module tcop_checks #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_i,
    input logic [2:0]    op_i,
    input logic [1:0]    phase_i,
    input logic          unit_i,
    input logic [31:0]   instr_i,
    input logic [1:0]    resp_o,
    input logic          nfiq_o,
    input logic          nirq_o,
    input logic [DW-1:0] tnow
);
    p_lines_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (nfiq_o && nirq_o));

    p_inc_only_long_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_o == 2'd3) |-> (req_i && (op_i == 3'd2 || op_i == 3'd3) && instr_i[22]));

    p_release_fiq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 3'd4 && unit_i && phase_i == 2'd0 && instr_i[23:20] == 4'd3)
        |=> nfiq_o);

    p_release_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 3'd4 && unit_i && phase_i == 2'd0 && instr_i[23:20] == 4'd4)
        |=> nirq_o);

    p_counter_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tnow == DW'($past(tnow) + 1'b1)));

    p_wait_unit_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 3'd4 && !unit_i && instr_i[23:20] != 4'd0) |-> (resp_o == 2'd2));
endmodule

bind tcop_top tcop_checks #(.DW(DW)) u_checks (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i),
    .phase_i(phase_i), .unit_i(unit_i), .instr_i(instr_i),
    .resp_o(resp_o), .nfiq_o(nfiq_o), .nirq_o(nirq_o), .tnow(tnow)
);

// File: tb/tcop_top_tb_top.sv
`timescale 1ns/1ps
module tcop_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  ph = '0;
    logic        unit = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  resp;
    logic [31:0] rdata;
    logic        nfiq, nirq;

    localparam logic [2:0] K_RD = 3'd0, K_WR = 3'd1, K_LD = 3'd2, K_ST = 3'd3, K_CMD = 3'd4;
    localparam logic [1:0] P_FIRST = 2'd0, P_BUSY = 2'd1, P_DATA = 2'd2;
    localparam logic [1:0] A_DONE = 2'd0, A_BUSY = 2'd1, A_CANT = 2'd2, A_INC = 2'd3;

    always #10 clk = ~clk;

    tcop_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .op_i(op), .phase_i(ph),
        .unit_i(unit), .instr_i(instr), .wdata_i(wdata), .resp_o(resp),
        .rdata_o(rdata), .nfiq_o(nfiq), .nirq_o(nirq)
    );

    typedef struct {
        bit          cr;
        logic [1:0]  r;
        bit          cd;
        logic [31:0] d;
        bit          cl;
        logic        f;
        logic        i;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 0;

    task automatic note(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expectations and compares mid low phase.
    always begin
        exp_t e;
        @(negedge clk);
        #5;
        while (q.size() > 0) begin
            e = q.pop_front();
            if (e.cr) note(resp === e.r, e.tag, "resp", 32'(resp), 32'(e.r));
            if (e.cd) note(rdata === e.d, e.tag, "rdata", rdata, e.d);
            if (e.cl) begin
                note(nfiq === e.f, e.tag, "nfiq", 32'(nfiq), 32'(e.f));
                note(nirq === e.i, e.tag, "nirq", 32'(nirq), 32'(e.i));
            end
        end
    end

    function automatic logic [31:0] ins(int cmd, int rn, int rd, int rm, bit lng);
        logic [31:0] v = '0;
        v[23:20] = 4'(cmd);
        v[19:16] = 4'(rn);
        v[15:12] = 4'(rd);
        v[3:0]   = 4'(rm);
        if (lng) v[22] = 1'b1;
        return v;
    endfunction

    task automatic drive(logic [2:0] k, logic [1:0] p, logic u, logic [31:0] w, logic [31:0] d);
        @(negedge clk);
        req = 1'b1; op = k; ph = p; unit = u; instr = w; wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        req = 1'b0; op = K_RD; ph = P_FIRST; instr = '0; wdata = '0;
    endtask

    task automatic exp_resp(logic [1:0] r, string tag);
        exp_t e;
        e = '{cr: 1, r: r, cd: 0, d: '0, cl: 0, f: 1'b1, i: 1'b1, tag: tag};
        q.push_back(e);
    endtask

    task automatic exp_rd(logic [1:0] r, logic [31:0] d, string tag);
        exp_t e;
        e = '{cr: 1, r: r, cd: 1, d: d, cl: 0, f: 1'b1, i: 1'b1, tag: tag};
        q.push_back(e);
    endtask

    task automatic exp_lines(logic f, logic i, string tag);
        exp_t e;
        e = '{cr: 0, r: '0, cd: 0, d: '0, cl: 1, f: f, i: i, tag: tag};
        q.push_back(e);
    endtask

    // Idle cycle with a line check.
    task automatic idle_lines(logic f, logic i, string tag);
        idle();
        exp_lines(f, i, tag);
    endtask

    task automatic wr(int idx, logic [31:0] d);
        drive(K_WR, P_FIRST, 1'b1, ins(0, idx, 0, 0, 0), d);
        exp_resp(A_DONE, "R2");
    endtask

    task automatic rd_chk(int idx, logic [31:0] d, string tag);
        drive(K_RD, P_FIRST, 1'b1, ins(0, idx, 0, 0, 0), '0);
        exp_rd(A_DONE, d, tag);
    endtask

    task automatic rd_get(int idx, output logic [31:0] v);
        drive(K_RD, P_FIRST, 1'b1, ins(0, idx, 0, 0, 0), '0);
        #4;
        v = rdata;
    endtask

    task automatic cmd(logic u, int c, int rm, logic [1:0] r, string tag);
        drive(K_CMD, P_FIRST, u, ins(c, 0, 0, rm, 0), '0);
        exp_resp(r, tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog run did not complete");
            summary();
            $finish;
        end
    end

    // Stimulus.
    initial begin
        logic [31:0] t_a, t_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        idle_lines(1'b1, 1'b1, "R1");
        rd_chk(9, 32'h0, "R1");
        rd_chk(15, 32'h0, "R1");

        // R2: register moves by bits 19:16, both units.
        wr(3, 32'hDEAD_BEEF);
        drive(K_WR, P_FIRST, 1'b0, ins(0, 12, 0, 0, 0), 32'h1234_5678);
        exp_resp(A_DONE, "R2");
        rd_chk(3, 32'hDEAD_BEEF, "R2");
        rd_chk(12, 32'h1234_5678, "R2");
        rd_chk(4, 32'h0, "R2");

        // R3: long load into r5 (bits 15:12), then long store.
        drive(K_LD, P_FIRST, 1'b0, ins(0, 9, 5, 0, 1), '0);
        exp_resp(A_DONE, "R3");
        for (int b = 0; b < 4; b++) begin
            drive(K_LD, P_DATA, 1'b0, ins(0, 9, 5, 0, 1), 32'hA000_0001 + 32'(b));
            exp_resp(b < 3 ? A_INC : A_DONE, "R3");
        end
        rd_chk(5, 32'hA000_0004, "R3");
        rd_chk(9, 32'h0, "R3");
        drive(K_ST, P_FIRST, 1'b0, ins(0, 0, 5, 0, 1), '0);
        exp_resp(A_DONE, "R3");
        for (int b = 0; b < 4; b++) begin
            drive(K_ST, P_DATA, 1'b0, ins(0, 0, 5, 0, 1), '0);
            exp_rd(b < 3 ? A_INC : A_DONE, 32'hA000_0004, "R3");
        end
        drive(K_LD, P_FIRST, 1'b0, ins(0, 0, 6, 0, 0), '0);
        exp_resp(A_DONE, "R3");
        drive(K_LD, P_DATA, 1'b0, ins(0, 0, 6, 0, 0), 32'h77);
        exp_resp(A_DONE, "R3");
        rd_chk(6, 32'h77, "R3");

        // R4: zero wait, then a 3-cycle wait.
        cmd(1'b0, 0, 0, A_DONE, "R4");
        wr(2, 32'd3);
        drive(K_CMD, P_FIRST, 1'b1, ins(0, 0, 0, 2, 0), '0);
        exp_resp(A_BUSY, "R4");
        for (int b = 1; b <= 3; b++) begin
            drive(K_CMD, P_BUSY, 1'b1, ins(0, 0, 0, 2, 0), '0);
            exp_resp(b < 3 ? A_BUSY : A_DONE, "R4");
        end

        // R5: fast line after 3 edges, release, immediate form.
        wr(1, 32'd3);
        cmd(1'b1, 1, 1, A_DONE, "R5");
        for (int b = 0; b < 3; b++) idle_lines(1'b1, 1'b1, "R5");
        idle_lines(1'b0, 1'b1, "R5");
        cmd(1'b1, 3, 0, A_DONE, "R7");
        idle_lines(1'b1, 1'b1, "R7");
        cmd(1'b1, 1, 0, A_DONE, "R5");
        idle_lines(1'b0, 1'b1, "R5");
        cmd(1'b1, 3, 0, A_DONE, "R7");
        idle_lines(1'b1, 1'b1, "R7");

        // R6: normal line after 3 edges, then release.
        cmd(1'b1, 2, 1, A_DONE, "R6");
        for (int b = 0; b < 3; b++) idle_lines(1'b1, 1'b1, "R6");
        idle_lines(1'b1, 1'b0, "R6");
        cmd(1'b1, 4, 0, A_DONE, "R7");
        idle_lines(1'b1, 1'b1, "R7");

        // R7: release cancels a pending delay.
        cmd(1'b1, 1, 1, A_DONE, "R7");
        cmd(1'b1, 3, 0, A_DONE, "R7");
        for (int b = 0; b < 5; b++) idle_lines(1'b1, 1'b1, "R7");

        // R10: a new delay replaces a pending longer one.
        wr(7, 32'd10);
        cmd(1'b1, 2, 7, A_DONE, "R10");
        idle();
        cmd(1'b1, 2, 1, A_DONE, "R10");
        for (int b = 0; b < 3; b++) idle_lines(1'b1, 1'b1, "R10");
        idle_lines(1'b1, 1'b0, "R10");
        cmd(1'b1, 4, 0, A_DONE, "R10");
        idle_lines(1'b1, 1'b1, "R10");

        // R8: two captures four cycles apart.
        cmd(1'b1, 5, 8, A_DONE, "R8");
        idle(); idle(); idle();
        cmd(1'b1, 5, 9, A_DONE, "R8");
        rd_get(8, t_a);
        rd_get(9, t_b);
        note(t_b - t_a == 32'd4, "R8", "capture delta", t_b - t_a, 32'd4);

        // R9: refused requests.
        cmd(1'b1, 6, 0, A_CANT, "R9");
        cmd(1'b1, 15, 0, A_CANT, "R9");
        cmd(1'b0, 1, 0, A_CANT, "R9");
        idle_lines(1'b1, 1'b1, "R9");
        idle_lines(1'b1, 1'b1, "R9");
        drive(K_LD, P_FIRST, 1'b1, ins(0, 0, 3, 0, 0), '0);
        exp_resp(A_CANT, "R9");
        drive(K_LD, P_DATA, 1'b1, ins(0, 0, 3, 0, 0), 32'h0);
        exp_resp(A_CANT, "R9");
        rd_chk(3, 32'hDEAD_BEEF, "R9");

        idle();
        idle();
        finished = 1;
        summary();
        $finish;
    end
endmodule